// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Accumulate Vector Unit

This block is the arithmetic lane array for a signed fixed-point multiply-accumulate that returns the upper half of a doubled, rounded product. It takes two 128-bit source vectors and a 128-bit accumulator vector, all holding signed two's-complement elements. For each active lane it forms the accumulator shifted into the upper half of a double-width value. It adds or subtracts twice the product of the two source elements, then adds a rounding constant of half a result step. The upper half of that sum is clamped to the element's signed range, and the clamped value is the lane result.

The element width is 16 bits (eight lanes) or 32 bits (four lanes). Lane i occupies bits [i*E+E-1 : i*E], so lane 0 sits in the least significant bits. The vector form computes every lane. The scalar form computes lane 0 only and writes zero to the upper lanes of the destination. The accumulate step is merged into the wide sum before rounding, so each lane saturates once and not twice. A sticky flag records that saturation has occurred until software-side logic clears it. The result is registered and appears one clock after the request.

Top module: `sat_rdmac_unit`

## Requirements
- R1: With `esize32`=0 and `sub_sel`=0, each 16-bit lane of `dst` equals clamp(((c<<16) + 2·a·b + 2^15) >> 16) over the signed 16-bit range, where a, b and c are the lane's signed elements and >> is an arithmetic shift.
- R2: With `sub_sel`=1 the doubled product is subtracted: clamp(((c<<E) − 2·a·b + 2^(E−1)) >> E).
- R3: With `esize32`=1 the same formula applies to four signed 32-bit lanes, with E=32.
- R4: Results above the signed maximum become 2^(E−1)−1 and results below the minimum become −2^(E−1). In particular a=b=−2^(E−1) with c=0 and accumulate gives 2^(E−1)−1.
- R5: With `scalar_sel`=1 only lane 0 is computed, and every bit of `dst` above lane 0 is zero.
- R6: `sat_sticky` becomes 1 in the cycle after a request in which any active lane saturates. Saturation in lanes that scalar form leaves inactive does not set it.
- R7: `sat_sticky` stays at 1 until `sat_clr` is sampled high. If a clear and a new saturating request arrive in the same cycle, the flag ends up set.
- R8: `dst` and `out_valid` update at the clock edge that samples `in_valid`=1. `out_valid` mirrors `in_valid` one cycle later, and `dst` holds its value while `in_valid` is 0.
- R9: After reset `dst` is zero and `out_valid` and `sat_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; operands sampled when high |
| sub_sel | input | 1 | 1 = subtract doubled product, 0 = add |
| scalar_sel | input | 1 | 1 = lane 0 only, 0 = all lanes |
| esize32 | input | 1 | 1 = 32-bit lanes, 0 = 16-bit lanes |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| src_a | input | 128 | First multiplicand vector |
| src_b | input | 128 | Second multiplicand vector |
| acc | input | 128 | Accumulator vector |
| dst | output | 128 | Registered result vector |
| out_valid | output | 1 | High one cycle after an accepted request |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Uniform random operands almost never saturate, and they seldom land exactly on a rounding boundary. The stimulus therefore draws each element from a mix that favours the extreme values −2^(E−1), 2^(E−1)−1, 0 and ±1, alongside fully random elements. This drives the accumulator and the doubled product to the same sign and pushes both saturation directions. A harder case is saturation confined to an inactive upper lane in scalar form, which must leave the flag clear. It is reached by a directed request with extreme values in lane 1 and harmless values in lane 0.

// File: rtl/sat_rdmac_unit.sv
module sat_rdmac_unit #(
  parameter int VEC_W    = 128,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             sub_sel,
  input  logic             scalar_sel,
  input  logic             esize32,
  input  logic             sat_clr,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc,
  output logic [VEC_W-1:0] dst,
  output logic             out_valid,
  output logic             sat_sticky
);
  localparam int MAX_LANES = VEC_W / NARROW_W;

  logic [VEC_W-1:0]     res_v [2];
  logic [MAX_LANES-1:0] hit_v [2];
  logic                 any_hit;

  for (genvar v = 0; v < 2; v++) begin : g_size
    localparam int E  = (v == 0) ? NARROW_W : WIDE_W;
    localparam int LN = VEC_W / E;
    localparam int XW = 2 * E + 3;
    localparam logic signed [XW-1:0] RND  = XW'(1) <<< (E - 1);
    localparam logic signed [XW-1:0] MAXV = (XW'(1) <<< (E - 1)) - XW'(1);
    localparam logic signed [XW-1:0] MINV = -(XW'(1) <<< (E - 1));

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
      if (i < LN) begin : g_on
        logic signed [E-1:0]   ea, eb, ec;
        logic signed [2*E-1:0] prod;
        logic signed [XW-1:0]  prod2, base, sum, hi;
        logic                  over, under, active;

        assign ea     = src_a[i*E +: E];
        assign eb     = src_b[i*E +: E];
        assign ec     = acc[i*E +: E];
        assign prod   = ea * eb;
        assign prod2  = XW'(prod) <<< 1;
        assign base   = XW'(ec) <<< E;
        assign sum    = sub_sel ? (base - prod2 + RND) : (base + prod2 + RND);
        assign hi     = sum >>> E;
        assign over   = hi > MAXV;
        assign under  = hi < MINV;
        assign active = !scalar_sel || (i == 0);

        assign hit_v[v][i]      = active && (over || under);
        assign res_v[v][i*E +: E] = !active ? '0 :
                                    over    ? {1'b0, {(E-1){1'b1}}} :
                                    under   ? {1'b1, {(E-1){1'b0}}} :
                                              hi[E-1:0];
      end else begin : g_off
        assign hit_v[v][i] = 1'b0;
      end
    end
  end

  assign any_hit = esize32 ? |hit_v[1] : |hit_v[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst        <= '0;
      out_valid  <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      sat_sticky <= (sat_sticky && !sat_clr) || (in_valid && any_hit);
      if (in_valid) dst <= esize32 ? res_v[1] : res_v[0];
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst)));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clr) |=> sat_sticky);

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !in_valid) |=> !sat_sticky);

  // R5
  scalar_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_sel && !esize32) |=> (dst[VEC_W-1:NARROW_W] == '0));

  // R4
  corner_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !esize32 && !sub_sel &&
     src_a[NARROW_W-1:0] == {1'b1, {(NARROW_W-1){1'b0}}} &&
     src_b[NARROW_W-1:0] == {1'b1, {(NARROW_W-1){1'b0}}} &&
     acc[NARROW_W-1:0] == '0)
    |=> (dst[NARROW_W-1:0] == {1'b0, {(NARROW_W-1){1'b1}}} && sat_sticky));
endmodule

// File: tb/sim_sat_rdmac_unit.sv
module sim_sat_rdmac_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, sub_sel = 1'b0, scalar_sel = 1'b0, esize32 = 1'b0, sat_clr = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, acc = '0;
  logic [127:0] dst;
  logic         out_valid, sat_sticky;

  int checks = 0, failures = 0;
  logic         sticky_m = 1'b0;
  logic [127:0] dst_m = '0;
  bit           done = 0;

  always #5 clk = ~clk;

  sat_rdmac_unit u0 (.clk, .rst_n, .in_valid, .sub_sel, .scalar_sel, .esize32, .sat_clr,
                     .src_a, .src_b, .acc, .dst, .out_valid, .sat_sticky);

  function automatic logic signed [127:0] sext(logic [127:0] v, int e);
    return (e == 16) ? {{112{v[15]}}, v[15:0]} : {{96{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [127:0] ref_op(logic [127:0] a, logic [127:0] b, logic [127:0] c,
                                          logic sub, logic scl, logic w32, output logic sat);
    int e = w32 ? 32 : 16;
    int ln = 128 / e;
    logic [127:0] r = '0;
    sat = 1'b0;
    for (int i = 0; i < ln; i++) begin
      logic signed [127:0] x, y, z, s, h, mx, mn;
      logic [127:0] lane;
      if (scl && i > 0) continue;
      x = sext(a >> (i * e), e);
      y = sext(b >> (i * e), e);
      z = sext(c >> (i * e), e);
      s = sub ? (z * (128'sd1 <<< e)) - 2 * x * y : (z * (128'sd1 <<< e)) + 2 * x * y;
      s = s + (128'sd1 <<< (e - 1));
      h = s >>> e;
      mx = (128'sd1 <<< (e - 1)) - 1;
      mn = -(128'sd1 <<< (e - 1));
      if (h > mx) begin h = mx; sat = 1'b1; end
      if (h < mn) begin h = mn; sat = 1'b1; end
      lane = w32 ? {96'd0, h[31:0]} : {112'd0, h[15:0]};
      r = r | (lane << (i * e));
    end
    return r;
  endfunction

  function automatic logic [31:0] pick_elem();
    case ($urandom % 6)
      0: return 32'h8000_0000;
      1: return 32'h7fff_ffff;
      2: return 32'h0000_0000;
      3: return 32'hffff_ffff;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] fix16(logic [31:0] v);
    if (v == 32'h8000_0000) return 32'h0000_8000;
    if (v == 32'h7fff_ffff) return 32'h0000_7fff;
    return {16'd0, v[15:0]};
  endfunction

  function automatic logic [127:0] rand_vec(logic w32);
    logic [127:0] v = '0;
    for (int i = 0; i < (w32 ? 4 : 8); i++) begin
      logic [31:0] el = pick_elem();
      if (w32) v[i*32 +: 32] = el;
      else     v[i*16 +: 16] = fix16(el);
    end
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(string req, logic [127:0] a, logic [127:0] b, logic [127:0] c,
                       logic sub, logic scl, logic w32, logic clr);
    logic s;
    @(negedge clk);
    src_a = a; src_b = b; acc = c; sub_sel = sub; scalar_sel = scl; esize32 = w32;
    sat_clr = clr; in_valid = 1'b1;
    dst_m = ref_op(a, b, c, sub, scl, w32, s);
    sticky_m = (sticky_m & ~clr) | s;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    chk(req, dst, dst_m);
    chk({req, " R8 out_valid"}, {127'd0, out_valid}, 128'd1);
    chk({req, " R6 sticky"}, {127'd0, sat_sticky}, {127'd0, sticky_m});
  endtask

  task automatic idle_cycle(string req, logic clr);
    @(negedge clk);
    src_a = rand_vec(1'b1); src_b = rand_vec(1'b1); acc = rand_vec(1'b1);
    sat_clr = clr;
    sticky_m = sticky_m & ~clr;
    @(posedge clk);
    @(negedge clk);
    sat_clr = 1'b0;
    chk({req, " dst hold"}, dst, dst_m);
    chk({req, " out_valid low"}, {127'd0, out_valid}, 128'd0);
    chk({req, " sticky"}, {127'd0, sat_sticky}, {127'd0, sticky_m});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 dst reset", dst, '0);
    chk("R9 out_valid reset", {127'd0, out_valid}, 128'd0);
    chk("R9 sticky reset", {127'd0, sat_sticky}, 128'd0);
    rst_n = 1'b1;

    // R4 corner: most negative squared, zero accumulator
    do_op("R4 corner16", 128'h8000, 128'h8000, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 corner16 lane0", {112'd0, dst[15:0]}, 128'h7fff);
    do_op("R4 corner32", 128'h8000_0000, 128'h8000_0000, '0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 corner32 lane0", {96'd0, dst[31:0]}, 128'h7fff_ffff);
    // R2 negative saturation through subtract
    do_op("R2 subsat", {8{16'h7fff}}, {8{16'h7fff}}, {8{16'h8000}}, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R2 subsat lane7", {112'd0, dst[127:112]}, 128'h8000);
    // R8 hold and R7 clear with no request
    idle_cycle("R7 clear idle", 1'b1);
    idle_cycle("R8 idle", 1'b0);
    // R1 simple: 0.5*0.5 + 0.25 in Q15
    do_op("R1 simple", {8{16'h4000}}, {8{16'h4000}}, {8{16'h2000}}, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 simple lane3", {112'd0, dst[63:48]}, 128'h4000);
    // R6 saturation in an inactive lane must not set the flag
    do_op("R6 inactive", {112'h8000, 16'h0001}, {112'h8000, 16'h0001}, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 inactive flag", {127'd0, sat_sticky}, 128'd0);
    chk("R5 upper zero", dst & ~128'hffff, '0);
    // R7 set wins over simultaneous clear
    do_op("R4 set", 128'h8000, 128'h8000, '0, 1'b0, 1'b1, 1'b0, 1'b0);
    do_op("R7 setclr", 128'h8000, 128'h8000, '0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 setclr flag", {127'd0, sat_sticky}, 128'd1);
    idle_cycle("R7 holds", 1'b0);
    idle_cycle("R7 clears", 1'b1);

    for (int n = 0; n < 300; n++) begin
      logic w32 = $urandom % 2;
      logic sub = $urandom % 2;
      logic scl = ($urandom % 4) == 0;
      logic clr = ($urandom % 5) == 0;
      string tag;
      tag = w32 ? (sub ? "R3 R2 rand" : "R3 rand") : (sub ? "R2 rand" : "R1 rand");
      if (scl) tag = {tag, " R5"};
      do_op(tag, rand_vec(w32), rand_vec(w32), rand_vec(w32), sub, scl, w32, clr);
      if (($urandom % 8) == 0) idle_cycle("R8 rand idle", ($urandom % 2) == 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule